// File: doc/BRIEF.md
# Signed Shift-Add Sequential Multiplier

This block forms the product of an 18-bit multiplier and an 18-bit multiplicand. It adds the multiplicand into a running high word whenever the lowest multiplier bit is 1, then shifts the high word and the multiplier word right by one place together. The result is left across two 18-bit registers: `ac` holds the high half and `mq` holds the low half. A start pulse loads the operands and a 6-bit step count. The block then runs one step per clock until its up-counting step counter wraps to zero, and raises `done` for one cycle.

In signed mode the block works in sign-magnitude. The multiplicand arrives as a magnitude, and its sign comes in on `link_in`. A negative multiplier, recognised by bit 17, is ones'-complemented before the arithmetic phase. The finished product is ones'-complemented when the two operand signs differ. The product sign is then written into both of the top two bits of `ac`. A step count smaller than 18 gives a reduced-precision product that sits higher in the register pair.

Top module: `mulseq_top`

## Requirements
- R1: After reset, `ac`, `mq`, `link_out`, `done` and `busy` are all 0.
- R2: In unsigned mode with step count n (0..18), multiplier M and multiplicand C, the final 36-bit value {ac,mq} equals (C × (M mod 2^n)) shifted left by 18−n, plus (M >> n). For example, C=2, M=5, n=4 gives ac=0 and mq=500000 (octal).
- R3: The carry out of each addition is kept. An 18-step unsigned product of two full-scale 18-bit operands is exact over all 36 bits.
- R4: A step count of 0 performs no steps. In unsigned mode, ac=0 and mq=M at completion.
- R5: In unsigned mode, `link_out` takes the value of `link_in` at start and holds it.
- R6: In signed mode, `link_out` is 0 from the accepted start through completion.
- R7: In signed mode, a multiplier with bit 17 set is ones'-complemented before the steps. Its magnitude is then used in the R2 formula.
- R8: In signed mode, the whole 36-bit result is ones'-complemented when the multiplier sign and `link_in` differ. It is left as is when they match.
- R9: In signed mode at completion, ac[17] and ac[16] both hold the product sign (multiplier sign XOR `link_in`), where 1 means negative.
- R10: `done` is high for exactly one cycle. It rises n+2 clock edges after the edge that accepts start, counting that edge as the first.
- R11: `start` is ignored while `busy` is high, so the running result is unaffected.
- R12: Each step shifts mq right by one place and discards its old bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start strobe, accepted only when idle |
| signed_mode | input | 1 | 1 selects signed multiply, 0 selects unsigned |
| step_count | input | 6 | Number of steps n |
| multiplier | input | 18 | Multiplier operand |
| mcand_mag | input | 18 | Multiplicand (magnitude in signed mode) |
| link_in | input | 1 | Multiplicand sign in signed mode, 0 in unsigned mode |
| ac | output | 18 | High half of the result |
| mq | output | 18 | Low half of the result |
| link_out | output | 1 | Link value after start |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The 2×5 four-step case pins the scaling of a reduced-precision product, and the full-scale 18-bit unsigned case catches a dropped adder carry. The four sign pairings tell whether the final complement keys on a sign mismatch and whether the multiplier pre-complement is applied. Step counts of 0 and 1 test the counter wrap at its boundary. A start pulse issued mid-run shows whether a busy operation can be disturbed.

// File: rtl/mulseq_pkg.sv
package mulseq_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_FIN  = 2'd2
   } mulseq_state_e;
endpackage

// File: rtl/mulseq_step.sv
// One sample-add-shift step: conditional add, then 2W-bit right shift with carry entering the top.
module mulseq_step #(
   parameter int W = 18
) (
   input  logic [W-1:0] ac_i,
   input  logic [W-1:0] mq_i,
   input  logic [W-1:0] mcand_i,
   output logic [W-1:0] ac_o,
   output logic [W-1:0] mq_o
);
   logic [W:0] sum;

   always_comb begin
      sum  = {1'b0, ac_i} + (mq_i[0] ? {1'b0, mcand_i} : '0);
      ac_o = sum[W:1];
      mq_o = {sum[0], mq_i[W-1:1]};
   end
endmodule

// File: rtl/mulseq_sign.sv
// Latches mode and operand signs at start; produces the product sign and the final-complement enable.
module mulseq_sign (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic signed_mode,
   input  logic link_in,
   input  logic mult_msb,
   output logic mode_q,
   output logic tmp_sign,
   output logic prod_sign,
   output logic negate
);
   logic mq_sign;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q   <= 1'b0;
         tmp_sign <= 1'b0;
         mq_sign  <= 1'b0;
      end else if (load) begin
         mode_q   <= signed_mode;
         tmp_sign <= signed_mode & link_in;
         mq_sign  <= signed_mode & mult_msb;
      end
   end

   assign prod_sign = tmp_sign ^ mq_sign;
   assign negate    = mode_q & prod_sign;
endmodule

// File: rtl/mulseq_finish.sv
// Final correction: optional ones' complement of the register pair and sign duplication.
module mulseq_finish #(
   parameter int W        = 18,
   parameter bit SIGN_DUP = 1'b1
) (
   input  logic [W-1:0] ac_i,
   input  logic [W-1:0] mq_i,
   input  logic         negate,
   input  logic         mode,
   input  logic         sign,
   output logic [W-1:0] ac_o,
   output logic [W-1:0] mq_o
);
   logic [W-1:0] ac_c;

   assign ac_c = negate ? ~ac_i : ac_i;
   assign mq_o = negate ? ~mq_i : mq_i;

   generate
      if (SIGN_DUP) begin : g_dup
         assign ac_o = mode ? {sign, sign, ac_c[W-3:0]} : ac_c;
      end else begin : g_single
         assign ac_o = mode ? {sign, ac_c[W-2:0]} : ac_c;
      end
   endgenerate
endmodule

// File: rtl/mulseq_top.sv
module mulseq_top #(
   parameter int W     = 18,
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             signed_mode,
   input  logic [CNT_W-1:0] step_count,
   input  logic [W-1:0]     multiplier,
   input  logic [W-1:0]     mcand_mag,
   input  logic             link_in,
   output logic [W-1:0]     ac,
   output logic [W-1:0]     mq,
   output logic             link_out,
   output logic             busy,
   output logic             done
);
   import mulseq_pkg::*;

   generate
      if (W < 3) begin : g_bad_w
         $error("mulseq_top: W must be at least 3");
      end
      if ((1 << CNT_W) <= W) begin : g_bad_cnt
         $error("mulseq_top: CNT_W too narrow for a full-precision count");
      end
   endgenerate

   mulseq_state_e    st;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_inc;
   logic [W-1:0]     ac_q, mq_q, mcand_q;
   logic [W-1:0]     ac_step, mq_step, ac_fin, mq_fin;
   logic             link_q, done_q;
   logic             accept;
   logic             mode_q, tmp_sign, prod_sign, negate;

   assign accept  = start && (st == ST_IDLE);
   assign cnt_inc = cnt_q + CNT_W'(1);

   mulseq_step #(.W(W)) u_step (
      .ac_i(ac_q), .mq_i(mq_q), .mcand_i(mcand_q),
      .ac_o(ac_step), .mq_o(mq_step)
   );

   mulseq_sign u_sign (
      .clk(clk), .rst_n(rst_n), .load(accept),
      .signed_mode(signed_mode), .link_in(link_in),
      .mult_msb(multiplier[W-1]),
      .mode_q(mode_q), .tmp_sign(tmp_sign),
      .prod_sign(prod_sign), .negate(negate)
   );

   mulseq_finish #(.W(W), .SIGN_DUP(1'b1)) u_fin (
      .ac_i(ac_q), .mq_i(mq_q), .negate(negate), .mode(mode_q),
      .sign(prod_sign), .ac_o(ac_fin), .mq_o(mq_fin)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         cnt_q   <= '0;
         ac_q    <= '0;
         mq_q    <= '0;
         mcand_q <= '0;
         link_q  <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (start) begin
                  ac_q    <= '0;
                  mq_q    <= (signed_mode && multiplier[W-1]) ? ~multiplier : multiplier;
                  mcand_q <= mcand_mag;
                  cnt_q   <= CNT_W'(0) - step_count;
                  link_q  <= signed_mode ? 1'b0 : link_in;
                  st      <= (step_count == '0) ? ST_FIN : ST_RUN;
               end
            end
            ST_RUN: begin
               ac_q  <= ac_step;
               mq_q  <= mq_step;
               cnt_q <= cnt_inc;
               if (cnt_inc == '0) st <= ST_FIN;
            end
            ST_FIN: begin
               ac_q   <= ac_fin;
               mq_q   <= mq_fin;
               done_q <= 1'b1;
               st     <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign ac       = ac_q;
   assign mq       = mq_q;
   assign link_out = link_q;
   assign busy     = (st != ST_IDLE);
   assign done     = done_q;
endmodule

// File: rtl/mulseq_chk.sv
module mulseq_chk #(
   parameter int W = 18
) (
   input logic         clk,
   input logic         rst_n,
   input logic [1:0]   st,
   input logic [W-1:0] ac,
   input logic [W-1:0] mq,
   input logic         link_out,
   input logic         done,
   input logic         mode_q,
   input logic         tmp_sign
);
   localparam logic [1:0] S_IDLE = 2'd0;
   localparam logic [1:0] S_RUN  = 2'd1;

   // R10
   p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R12
   p_mq_shift_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_RUN) |=> (mq[W-2:0] == $past(mq[W-1:1])));

   // R6
   p_link_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (st != S_IDLE && mode_q) |-> (link_out == 1'b0));

   // R9
   p_sign_dup_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (done && mode_q) |-> (ac[W-1] == ac[W-2]));

   // R11
   p_sign_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (st != S_IDLE && $past(st) != S_IDLE) |-> ($stable(tmp_sign) && $stable(mode_q)));
endmodule

bind mulseq_top mulseq_chk #(.W(W)) u_chk (
   .clk(clk), .rst_n(rst_n), .st(st), .ac(ac), .mq(mq),
   .link_out(link_out), .done(done), .mode_q(mode_q), .tmp_sign(tmp_sign)
);

// File: tb/mulseq_top_tb.sv
module mulseq_top_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        signed_mode = 1'b0;
   logic [5:0]  step_count = '0;
   logic [17:0] multiplier = '0;
   logic [17:0] mcand_mag = '0;
   logic        link_in = 1'b0;
   logic [17:0] ac, mq;
   logic        link_out, busy, done;

   int checks = 0;
   int failures = 0;
   logic [36:0] exp_q[$];
   string       tag_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   mulseq_top u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .signed_mode(signed_mode),
      .step_count(step_count), .multiplier(multiplier), .mcand_mag(mcand_mag),
      .link_in(link_in), .ac(ac), .mq(mq), .link_out(link_out),
      .busy(busy), .done(done)
   );

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0o expected=%0o", req, act, expv);
      end
   endtask

   // Expected {link, ac, mq} from the requirement formulas
   function automatic logic [36:0] model(input logic [17:0] m, input logic [17:0] c,
                                         input logic l, input logic s, input int n);
      logic        msg, ps;
      logic [17:0] me, mask;
      logic [71:0] t;
      logic [35:0] r;
      msg  = s & m[17];
      me   = msg ? ~m : m;
      mask = (n >= 18) ? 18'h3FFFF : ((18'h1 << n) - 18'h1);
      t    = 72'(c) * 72'(me & mask);
      t    = (t << (18 - n)) + 72'(me >> n);
      r    = t[35:0];
      ps   = msg ^ l;
      if (s && ps) r = ~r;
      if (s) begin
         r[35] = ps;
         r[34] = ps;
      end
      return {(s ? 1'b0 : l), r};
   endfunction

   // Monitor: pop the expected item on each done pulse
   always @(negedge clk) begin
      if (rst_n && done) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R10 unexpected done", 64'(done), 64'(0));
         end else begin
            logic [36:0] e;
            string       t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(ac == e[35:18], {t, " ac"}, 64'(ac), 64'(e[35:18]));
            check(mq == e[17:0],  {t, " mq"}, 64'(mq), 64'(e[17:0]));
            check(link_out == e[36], {t, " link"}, 64'(link_out), 64'(e[36]));
         end
      end
   end

   task automatic run_op(input logic [17:0] m, input logic [17:0] c, input logic l,
                         input logic s, input int n, input bit intr, input string tag);
      int cyc;
      exp_q.push_back(model(m, c, l, s, n));
      tag_q.push_back(tag);
      @(negedge clk);
      multiplier  = m;
      mcand_mag   = c;
      link_in     = l;
      signed_mode = s;
      step_count  = 6'(n);
      start       = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cyc = 1;
      while (!done && cyc < 200) begin
         if (cyc == 1 && s) check(link_out == 1'b0, "R6 link cleared while running", 64'(link_out), 64'(0));
         @(negedge clk);
         cyc++;
         if (intr && cyc == 2) begin
            // R11: disturbing start while busy
            multiplier = 18'o777777; mcand_mag = 18'o123456;
            link_in = ~l; signed_mode = ~s; step_count = 6'd3; start = 1'b1;
         end else if (intr && cyc == 3) begin
            start = 1'b0;
         end
      end
      check(cyc == n + 2, "R10 done latency", 64'(cyc), 64'(n + 2));
      @(negedge clk);
      check(done == 1'b0, "R10 done single cycle", 64'(done), 64'(0));
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check(ac == 0 && mq == 0, "R1 reset ac/mq", 64'({ac, mq}), 64'(0));
      check(!done && !busy && !link_out, "R1 reset flags", 64'({done, busy, link_out}), 64'(0));
      rst_n = 1'b1;
      @(negedge clk);

      run_op(18'd5, 18'd2, 1'b0, 1'b0, 4, 1'b0, "R2 R12 2x5 n=4");
      check(mq == 18'o500000, "R2 scaled example mq", 64'(mq), 64'(18'o500000));
      run_op(18'o001234, 18'o000567, 1'b0, 1'b0, 18, 1'b0, "R2 full unsigned");
      run_op(18'o777777, 18'o777777, 1'b0, 1'b0, 18, 1'b0, "R3 carry full-scale");
      run_op(18'o654321, 18'o000777, 1'b0, 1'b0, 0, 1'b0, "R4 zero count");
      run_op(18'o000007, 18'o000003, 1'b0, 1'b0, 1, 1'b0, "R4 one step");
      run_op(18'o012345, 18'o000017, 1'b1, 1'b0, 18, 1'b0, "R5 unsigned link kept");
      run_op(18'o000123, 18'o001234, 1'b0, 1'b1, 18, 1'b0, "R8 signed ++");
      run_op(18'o000123, 18'o001234, 1'b1, 1'b1, 18, 1'b0, "R8 R9 signed +-");
      run_op(18'o777654, 18'o001234, 1'b0, 1'b1, 18, 1'b0, "R7 R9 signed -+");
      run_op(18'o777654, 18'o001234, 1'b1, 1'b1, 18, 1'b0, "R7 R8 signed --");
      run_op(18'o700005, 18'o000002, 1'b0, 1'b1, 4, 1'b0, "R7 R9 signed reduced");
      run_op(18'o000321, 18'o000456, 1'b0, 1'b0, 18, 1'b1, "R11 start ignored");
      run_op(18'o000011, 18'o000022, 1'b1, 1'b1, 18, 1'b1, "R11 R6 signed start ignored");

      repeat (3) @(negedge clk);
      check(exp_q.size() == 0, "R10 all results seen", 64'(exp_q.size()), 64'(0));
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule